// File: doc/BRIEF.md
# Jump-Counter Microsequencer

This block produces the next control state for a microcoded multicycle processor. It holds a small micro-PC register. On every clock edge a two-bit sequencing action, taken from the current control word, picks the next value. The action can keep the micro-PC where it is, step it by one, clear it to the fetch state, or jump through a dispatch map indexed by the instruction opcode. Keeping the value gives wait states, so the controller can stall without any extra states.

The micro-PC and a one-hot decode of it are outputs that the control store and datapath use. The equal flag from the datapath enters the block, but it only decides whether the PC is written in the branch state. It never changes the sequence. An opcode with no dispatch entry sends the controller back to fetch.

The walk through the states follows a fixed scheme:
- Fetch (0000) steps to decode (0001), and decode dispatches.
- R-type runs 0100 then 0101 and clears.
- OR-immediate runs 0110 then 0111 and clears.
- Load runs 1000, 1001 and 1010, then clears.
- Store runs 1011 then 1100 and clears.
- Branch (0011) clears at once.

Top module: `useq_jump_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-PC becomes 0000 at that edge, and `state_idx` shows bit 0 alone.
- R2: Action code 00 (hold) leaves the micro-PC unchanged at the edge.
- R3: Action code 01 (step) sets the micro-PC to its value plus one, and 1111 wraps to 0000.
- R4: Action code 11 (clear) sets the micro-PC to 0000.
- R5: Action code 10 (dispatch) loads the map entry for `opcode`. The entries are 000000→0100, 000100→0011, 001101→0110, 100011→1000 and 101011→1011.
- R6: Dispatch on an opcode that is not listed in R5 loads 0000.
- R7: `state_idx` is one-hot, with bit number equal to the micro-PC value set.
- R8: The `eq` input has no effect on the next micro-PC under any action.
- R9: Each instruction class follows its state walk when driven with the stated actions:
  - fetch step, then decode dispatch;
  - R-type: step then clear;
  - OR-immediate: step then clear;
  - load: step, step, clear;
  - store: step then clear;
  - branch: clear.
- R10: Reset takes priority over any action code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode used by dispatch |
| act | input | 2 | Sequencing action: 00 hold, 01 step, 10 dispatch, 11 clear |
| eq | input | 1 | Operand-equal flag from the datapath |
| upc | output | 4 | Current micro-PC |
| state_idx | output | 16 | One-hot decode of the micro-PC |

## Verification
The assertions assume that `act`, `opcode` and `eq` are stable, known values at each rising edge. They also assume that reset is applied at the first edge, so the micro-PC is defined before any property is evaluated. The stimulus sets every input one time unit after an edge and holds it through the next edge. The stimulus also starts with reset high, so each assertion sees only defined state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W = 4;
  localparam int OP_W  = 6;
  localparam int NSTATE = 1 << UPC_W;

  typedef logic [UPC_W-1:0] upc_t;
  typedef logic [OP_W-1:0]  op_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'b00,
    ACT_STEP  = 2'b01,
    ACT_DISP  = 2'b10,
    ACT_CLEAR = 2'b11
  } act_e;

  // dispatch opcodes
  localparam op_t OPC_RTYPE = 6'b000000;
  localparam op_t OPC_BEQ   = 6'b000100;
  localparam op_t OPC_ORI   = 6'b001101;
  localparam op_t OPC_LW    = 6'b100011;
  localparam op_t OPC_SW    = 6'b101011;

  // dispatch targets
  localparam upc_t ST_FETCH = 4'b0000;
  localparam upc_t ST_BEQ   = 4'b0011;
  localparam upc_t ST_RTYPE = 4'b0100;
  localparam upc_t ST_ORI   = 4'b0110;
  localparam upc_t ST_LW    = 4'b1000;
  localparam upc_t ST_SW    = 4'b1011;
endpackage

// File: rtl/useq_map_rom.sv
module useq_map_rom
  import useq_pkg::*;
(
  input  op_t  opcode,
  output upc_t target
);
  always_comb begin
    unique case (opcode)
      OPC_RTYPE: target = ST_RTYPE;
      OPC_BEQ:   target = ST_BEQ;
      OPC_ORI:   target = ST_ORI;
      OPC_LW:    target = ST_LW;
      OPC_SW:    target = ST_SW;
      default:   target = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/useq_counter.sv
module useq_counter
  import useq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  act_e act,
  input  upc_t load_val,
  output upc_t upc
);
  upc_t upc_q, upc_d;

  always_comb begin
    unique case (act)
      ACT_HOLD:  upc_d = upc_q;
      ACT_STEP:  upc_d = upc_q + upc_t'(1);
      ACT_DISP:  upc_d = load_val;
      ACT_CLEAR: upc_d = ST_FETCH;
      default:   upc_d = upc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= ST_FETCH;
    else     upc_q <= upc_d;
  end

  assign upc = upc_q;

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    act == ACT_HOLD |=> $stable(upc_q)); // R2
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    act == ACT_STEP |=> upc_q == upc_t'($past(upc_q) + 1'b1)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    act == ACT_CLEAR |=> upc_q == '0); // R4
  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (rst)
    act == ACT_DISP |=> upc_q == $past(load_val)); // R5
endmodule

// File: rtl/useq_onehot.sv
module useq_onehot
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  upc_t              upc,
  output logic [NSTATE-1:0] idx
);
  for (genvar g = 0; g < NSTATE; g++) begin : g_dec
    assign idx[g] = (upc == upc_t'(g));
  end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(idx) == 1); // R7
  AST_BIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    idx[upc] == 1'b1); // R7
endmodule

// File: rtl/useq_jump_counter.sv
module useq_jump_counter
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [1:0]        act,
  input  logic              eq,
  output logic [UPC_W-1:0]  upc,
  output logic [NSTATE-1:0] state_idx
);
  upc_t map_tgt;
  act_e act_e_w;

  assign act_e_w = act_e'(act);

  useq_map_rom u_map (
    .opcode (opcode),
    .target (map_tgt)
  );

  useq_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .act      (act_e_w),
    .load_val (map_tgt),
    .upc      (upc)
  );

  useq_onehot u_dec (
    .clk (clk),
    .rst (rst),
    .upc (upc),
    .idx (state_idx)
  );

  AST_UNMAPPED_FETCH: assert property (@(posedge clk) disable iff (rst)
    (act == 2'b10 && opcode != OPC_RTYPE && opcode != OPC_BEQ &&
     opcode != OPC_ORI && opcode != OPC_LW && opcode != OPC_SW)
    |=> upc == ST_FETCH); // R6
  AST_BRANCH_EQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (upc == ST_BEQ && act == 2'b11 && eq) |=> upc == ST_FETCH); // R8
  AST_HOLD_EQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (act == 2'b00 && eq) |=> $stable(upc)); // R8
endmodule

// File: tb/sim_useq_jump_counter.sv
`timescale 1ns/100ps
module sim_useq_jump_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [1:0] act = 2'b00;
  logic eq = 1'b0;
  logic [3:0] upc;
  logic [15:0] state_idx;
  int checks = 0;
  int errors = 0;

  localparam logic [1:0] HOLD = 2'b00, STEP = 2'b01, DISP = 2'b10, CLR = 2'b11;

  always #2.5 clk = ~clk;

  useq_jump_counter u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .act(act), .eq(eq),
    .upc(upc), .state_idx(state_idx)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (upc !== exp || state_idx !== (16'd1 << exp)) begin
      errors++;
      $display("FAIL %s upc=%b idx=%h expected upc=%b idx=%h",
               req, upc, state_idx, exp, 16'd1 << exp);
    end
  endtask

  // drive inputs, let one edge pass, then sample 1 ns after it
  task automatic step(input logic [1:0] a, input logic [5:0] op, input logic e);
    act = a; opcode = op; eq = e;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst = 1'b1; step(HOLD, 6'd0, 1'b0); rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(); check("R1 reset", 4'd0);
  endtask

  task automatic t_hold;
    do_reset(); step(STEP, 0, 0); step(STEP, 0, 0);
    for (int i = 0; i < 3; i++) begin step(HOLD, 6'b101011, 0); check("R2 hold", 4'd2); end
  endtask

  task automatic t_step_wrap;
    do_reset();
    for (int i = 1; i < 16; i++) begin step(STEP, 0, 0); check("R3 step", 4'(i)); end
    step(STEP, 0, 0); check("R3 wrap", 4'd0);
  endtask

  task automatic t_clear;
    do_reset(); step(DISP, 6'b100011, 0); step(STEP, 0, 0); check("R3 step", 4'd9);
    step(CLR, 6'b000100, 1); check("R4 clear", 4'd0);
  endtask

  task automatic t_map;
    logic [5:0] ops [5] = '{6'b000000, 6'b000100, 6'b001101, 6'b100011, 6'b101011};
    logic [3:0] tg  [5] = '{4'b0100, 4'b0011, 4'b0110, 4'b1000, 4'b1011};
    for (int i = 0; i < 5; i++) begin
      do_reset(); step(STEP, 0, 0); step(DISP, ops[i], 0); check("R5 dispatch", tg[i]);
    end
  endtask

  task automatic t_unmapped;
    logic [5:0] ops [3] = '{6'b111111, 6'b000001, 6'b100010};
    for (int i = 0; i < 3; i++) begin
      do_reset(); step(STEP, 0, 0); step(STEP, 0, 0); step(DISP, ops[i], 0);
      check("R6 unmapped", 4'd0);
    end
  endtask

  task automatic t_equal;
    do_reset(); step(STEP, 0, 1); step(DISP, 6'b000100, 1); check("R8 eq", 4'd3);
    step(HOLD, 0, 1); check("R8 eq hold", 4'd3);
    step(CLR, 0, 1); check("R8 eq branch", 4'd0);
    step(STEP, 0, 0); step(DISP, 6'b000100, 0); step(CLR, 0, 0); check("R8 no eq branch", 4'd0);
    step(STEP, 0, 1); check("R8 eq step", 4'd1);
  endtask

  task automatic walk(input logic [5:0] op, input logic [3:0] first, input int n_step);
    do_reset(); step(STEP, 0, 0); check("R9 fetch", 4'd1);
    step(DISP, op, 0); check("R9 decode", first);
    for (int i = 1; i <= n_step; i++) begin
      step(STEP, 0, 0); check("R9 walk", 4'(first + i));
    end
    step(CLR, 0, 0); check("R9 return", 4'd0);
  endtask

  task automatic t_walks;
    walk(6'b000000, 4'b0100, 1);
    walk(6'b001101, 4'b0110, 1);
    walk(6'b100011, 4'b1000, 2);
    walk(6'b101011, 4'b1011, 1);
    walk(6'b000100, 4'b0011, 0);
  endtask

  task automatic t_reset_prio;
    do_reset(); step(STEP, 0, 0); step(STEP, 0, 0);
    rst = 1'b1; step(STEP, 0, 0); check("R10 prio step", 4'd0);
    step(DISP, 6'b100011, 0); check("R10 prio disp", 4'd0);
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_hold();
    t_step_wrap();
    t_clear();
    t_map();
    t_unmapped();
    t_equal();
    t_walks();
    t_reset_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule